// File: doc/BRIEF.md
# Word/Byte Arithmetic-Logic Unit with Status Flags

This block computes one arithmetic, logic or single-bit shift operation per cycle on 16-bit or 8-bit operands and produces the result together with six status flags: carry, parity, auxiliary carry, zero, sign and overflow. Result and next-flag outputs are combinational. The flags are also kept in a register that loads when the flag write enable is high. The stored carry flag feeds the carry-with-add, borrow-with-subtract and the carry-preserving increment and decrement operations.

A width select picks byte or word operation. In byte mode the sign bit is bit 7, the upper operand bytes are ignored and the upper result byte is zero. Parity always looks at the low eight result bits.

Top module: `word_alu`

## Requirements
- R1: Opcode 0 (add) gives a+b and opcode 1 (add with carry) gives a+b+stored carry, truncated to the active width. Carry is set when the sum exceeds the active width.
- R2: Opcode 2 (subtract) gives a-b and opcode 3 (subtract with borrow) gives a-b-stored carry. Carry is set when a borrow out of the top bit is needed.
- R3: Parity (flag bit 1) is set when the low 8 result bits hold an even number of ones, in both widths, for every opcode that updates flags.
- R4: Auxiliary carry (flag bit 2) is the carry or borrow out of bit 3 for opcodes 0-3, 7 and 8. Logic opcodes 4-6 and shift opcodes 10-11 clear it.
- R5: Zero (flag bit 3) is set when the active-width result is zero. Sign (flag bit 4) copies the active-width MSB.
- R6: Overflow (flag bit 5) is set for opcodes 0-3, 7 and 8 when the signed result leaves the active-width range.
- R7: When word_i is 0 (byte mode), the MSB is bit 7, a_i[15:8] and b_i[15:8] have no effect, and res_o[15:8] is zero for opcodes 0-11.
- R8: Logic opcodes 4 (AND), 5 (OR) and 6 (XOR) clear carry (flag bit 0) and overflow.
- R9: Opcodes 7 (a+1) and 8 (a-1) leave carry equal to the stored carry.
- R10: Opcode 9 gives the bitwise complement of a and leaves all six flags equal to the stored flags.
- R11: Opcode 10 (shift left) and opcode 11 (shift right) move one bit position and fill with zero. Carry takes the bit shifted out. Overflow is the result MSB XOR carry for the left shift, and the original MSB for the right shift.
- R12: flags_o resets to 0. It loads flags_nxt_o at a rising clock edge when flag_we_i is 1 and holds otherwise. Opcodes 12-15 pass a_i unchanged to res_o and leave all flags unchanged. The flag vector order is {overflow, sign, zero, aux, parity, carry}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| op_i | input | 4 | Operation code |
| word_i | input | 1 | 1 = word operation, 0 = byte operation |
| flag_we_i | input | 1 | Load stored flags at the next edge |
| res_o | output | 16 | Result |
| flags_nxt_o | output | 6 | Flags produced by the current operation |
| flags_o | output | 6 | Stored flags |

## Verification
The stored-flag write and a read of the stored carry can fall in the same cycle. An add-with-carry, subtract-with-borrow, increment or decrement can read carry while flag_we_i overwrites it at that same edge. The bench provokes this by issuing these carry-reading opcodes back to back with the write enable high, in directed runs and in a long random mix. The reference model judges each result against the carry held before the edge, and each stored value against the flags of the operation just completed.

// File: rtl/word_alu_pkg.sv
package word_alu_pkg;
  localparam int FLAG_W = 6;
  localparam int PAR_W  = 8;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0, OP_ADC = 4'd1, OP_SUB = 4'd2, OP_SBB = 4'd3,
    OP_AND = 4'd4, OP_OR  = 4'd5, OP_XOR = 4'd6, OP_INC = 4'd7,
    OP_DEC = 4'd8, OP_NOT = 4'd9, OP_SHL = 4'd10, OP_SHR = 4'd11
  } alu_op_e;

  typedef struct packed {
    logic of_f;
    logic sf_f;
    logic zf_f;
    logic af_f;
    logic pf_f;
    logic cf_f;
  } flags_t;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         word_i,
  input  logic         inv_b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         c_msb_o,
  output logic         c_nib_o
);
  localparam int HW = W / 2;

  logic [W-1:0] y;
  logic [W:0]   full;
  logic [HW:0]  half;

  assign y    = inv_b_i ? ~b_i : b_i;
  assign full = {1'b0, a_i} + {1'b0, y} + {{W{1'b0}}, cin_i};
  assign half = {1'b0, a_i[HW-1:0]} + {1'b0, y[HW-1:0]} + {{HW{1'b0}}, cin_i};

  assign sum_o   = word_i ? full[W-1:0] : {{HW{1'b0}}, half[HW-1:0]};
  assign cout_o  = word_i ? full[W] : half[HW];
  // carry into MSB recovered from sum bit and operand bits
  assign c_msb_o = word_i ? (a_i[W-1] ^ y[W-1] ^ full[W-1])
                          : (a_i[HW-1] ^ y[HW-1] ^ half[HW-1]);
  assign c_nib_o = a_i[4] ^ y[4] ^ full[4];
endmodule

// File: rtl/alu_bitops.sv
module alu_bitops
  import word_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         word_i,
  input  alu_op_e      op_i,
  output logic [W-1:0] res_o,
  output logic         sh_out_o
);
  localparam int HW = W / 2;

  logic [W-1:0] r;

  always_comb begin
    r        = '0;
    sh_out_o = 1'b0;
    unique case (op_i)
      OP_AND: r = a_i & b_i;
      OP_OR:  r = a_i | b_i;
      OP_XOR: r = a_i ^ b_i;
      OP_NOT: r = ~a_i;
      OP_SHL: begin
        r        = {a_i[W-2:0], 1'b0};
        sh_out_o = word_i ? a_i[W-1] : a_i[HW-1];
      end
      OP_SHR: begin
        r        = word_i ? {1'b0, a_i[W-1:1]} : {{(HW+1){1'b0}}, a_i[HW-1:1]};
        sh_out_o = a_i[0];
      end
      default: r = '0;
    endcase
  end

  assign res_o = word_i ? r : {{HW{1'b0}}, r[HW-1:0]};
endmodule

// File: rtl/alu_status.sv
module alu_status #(
  parameter int FW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [FW-1:0] d_i,
  output logic [FW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/word_alu.sv
module word_alu
  import word_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [W-1:0]      a_i,
  input  logic [W-1:0]      b_i,
  input  logic [3:0]        op_i,
  input  logic              word_i,
  input  logic              flag_we_i,
  output logic [W-1:0]      res_o,
  output logic [FLAG_W-1:0] flags_nxt_o,
  output logic [FLAG_W-1:0] flags_o
);
  localparam int HW = W / 2;

  alu_op_e      op;
  flags_t       q, nxt;
  logic [W-1:0] b_eff, sum, bit_res, res;
  logic         inv_b, cin, sub, cout, c_msb, c_nib, sh_out, upd_szp, msb;

  assign op = alu_op_e'(op_i);
  assign q  = flags_t'(flags_o);

  always_comb begin
    b_eff = b_i;
    inv_b = 1'b0;
    cin   = 1'b0;
    sub   = 1'b0;
    unique case (op)
      OP_ADC: cin = q.cf_f;
      OP_SUB: begin inv_b = 1'b1; cin = 1'b1;    sub = 1'b1; end
      OP_SBB: begin inv_b = 1'b1; cin = ~q.cf_f; sub = 1'b1; end
      OP_INC: b_eff = W'(1);
      OP_DEC: begin b_eff = W'(1); inv_b = 1'b1; cin = 1'b1; sub = 1'b1; end
      default: ;
    endcase
  end

  alu_addsub #(.W(W)) u_addsub (
    .a_i(a_i), .b_i(b_eff), .word_i(word_i), .inv_b_i(inv_b), .cin_i(cin),
    .sum_o(sum), .cout_o(cout), .c_msb_o(c_msb), .c_nib_o(c_nib)
  );

  alu_bitops #(.W(W)) u_bitops (
    .a_i(a_i), .b_i(b_i), .word_i(word_i), .op_i(op),
    .res_o(bit_res), .sh_out_o(sh_out)
  );

  assign msb = word_i ? res[W-1] : res[HW-1];

  always_comb begin
    res     = a_i;
    nxt     = q;
    upd_szp = 1'b1;
    unique case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_INC, OP_DEC: begin
        res      = sum;
        nxt.cf_f = (op == OP_INC || op == OP_DEC) ? q.cf_f : (cout ^ sub);
        nxt.af_f = c_nib ^ sub;
        nxt.of_f = c_msb ^ cout;
      end
      OP_AND, OP_OR, OP_XOR: begin
        res      = bit_res;
        nxt.cf_f = 1'b0;
        nxt.af_f = 1'b0;
        nxt.of_f = 1'b0;
      end
      OP_NOT: begin
        res     = bit_res;
        upd_szp = 1'b0;
      end
      OP_SHL, OP_SHR: begin
        res      = bit_res;
        nxt.cf_f = sh_out;
        nxt.af_f = 1'b0;
        nxt.of_f = 1'b0;
      end
      default: upd_szp = 1'b0;
    endcase
    if (upd_szp) begin
      nxt.zf_f = word_i ? (res == '0) : (res[HW-1:0] == '0);
      nxt.sf_f = msb;
      nxt.pf_f = ~^res[PAR_W-1:0];
      if (op == OP_SHL) nxt.of_f = msb ^ sh_out;
      if (op == OP_SHR) nxt.of_f = word_i ? a_i[W-1] : a_i[HW-1];
    end
  end

  assign res_o       = res;
  assign flags_nxt_o = nxt;

  alu_status #(.FW(FLAG_W)) u_status (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(flag_we_i),
    .d_i(flags_nxt_o), .q_o(flags_o)
  );
endmodule

// File: rtl/word_alu_chk.sv
module word_alu_chk #(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [3:0]   op_i,
  input logic         word_i,
  input logic         flag_we_i,
  input logic [W-1:0] res_o,
  input logic [5:0]   flags_nxt_o,
  input logic [5:0]   flags_o
);
  localparam int HW = W / 2;

  // R12
  flag_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_i |=> flags_o == $past(flags_nxt_o));
  // R12
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_we_i |=> $stable(flags_o));
  // R8
  logic_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i inside {4'd4, 4'd5, 4'd6}) |-> (flags_nxt_o[0] == 1'b0 && flags_nxt_o[5] == 1'b0));
  // R9
  incdec_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i inside {4'd7, 4'd8}) |-> flags_nxt_o[0] == flags_o[0]);
  // R10
  not_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd9) |-> flags_nxt_o == flags_o);
  // R7
  byte_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!word_i && op_i <= 4'd11) |-> res_o[W-1:HW] == '0);
  // R5
  zero_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i <= 4'd11 && op_i != 4'd9) |-> flags_nxt_o[3] == (res_o == '0));
endmodule

bind word_alu word_alu_chk #(.W(W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .word_i(word_i),
  .flag_we_i(flag_we_i), .res_o(res_o), .flags_nxt_o(flags_nxt_o), .flags_o(flags_o)
);

// File: tb/word_alu_tb_top.sv
`timescale 1ns/1ps
module word_alu_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] a = '0, b = '0;
  logic [3:0]  op = '0;
  logic        word = 1'b1, we = 1'b0;
  logic [15:0] res;
  logic [5:0]  fnxt, fq;
  logic [5:0]  m_flags = '0;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  word_alu dut_i (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b), .op_i(op), .word_i(word),
    .flag_we_i(we), .res_o(res), .flags_nxt_o(fnxt), .flags_o(fq)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input int o);
    case (o)
      0, 1: return "R1";
      2, 3: return "R2";
      4, 5, 6: return "R8";
      7, 8: return "R9";
      9: return "R10";
      10, 11: return "R11";
      default: return "R12";
    endcase
  endfunction

  // flags packed {of,sf,zf,af,pf,cf}
  task automatic model(input logic [15:0] ai, input logic [15:0] bi, input int o,
                       input bit wd, input logic [5:0] fin,
                       output logic [15:0] r, output logic [5:0] f);
    int w = wd ? 16 : 8;
    int m = (1 << w) - 1;
    int hb = 1 << (w - 1);
    int x = int'(ai) & m;
    int y = int'(bi) & m;
    int c = int'(fin[0]);
    int s = 0, rr = 0, ones = 0;
    bit cf = fin[0], af = fin[2], of = fin[5], szp = 1'b1;
    case (o)
      0, 1: begin
        if (o == 0) c = 0;
        s = x + y + c; rr = s & m; cf = s > m;
        af = ((x & 15) + (y & 15) + c) > 15;
        of = ((x & hb) == (y & hb)) && ((rr & hb) != (x & hb));
      end
      2, 3: begin
        if (o == 2) c = 0;
        s = x - y - c; rr = s & m; cf = s < 0;
        af = ((x & 15) - (y & 15) - c) < 0;
        of = ((x & hb) != (y & hb)) && ((rr & hb) != (x & hb));
      end
      4, 5, 6: begin
        rr = (o == 4) ? (x & y) : (o == 5) ? (x | y) : (x ^ y);
        cf = 0; af = 0; of = 0;
      end
      7: begin rr = (x + 1) & m; af = (x & 15) == 15; of = x == hb - 1; end
      8: begin rr = (x - 1) & m; af = (x & 15) == 0;  of = x == hb; end
      9: begin rr = (~x) & m; szp = 1'b0; end
      10: begin cf = (x & hb) != 0; rr = (x << 1) & m; of = ((rr & hb) != 0) ^ cf; af = 0; end
      11: begin cf = x & 1; rr = x >> 1; of = (x & hb) != 0; af = 0; end
      default: begin rr = int'(ai); szp = 1'b0; end
    endcase
    r = 16'(rr);
    f = fin;
    if (szp) begin
      for (int i = 0; i < 8; i++) ones += (rr >> i) & 1;
      f = {of, (rr & hb) != 0, rr == 0, af, ones % 2 == 0, cf};
    end
  endtask

  task automatic apply(input logic [15:0] ai, input logic [15:0] bi, input int o,
                       input bit wd, input bit wr, input string tag);
    logic [15:0] er;
    logic [5:0]  ef;
    @(negedge clk);
    a = ai; b = bi; op = 4'(o); word = wd; we = wr;
    model(ai, bi, o, wd, m_flags, er, ef);
    #1;
    check(tag, "result", int'(res), int'(er));
    check(tag, "next flags", int'(fnxt), int'(ef));
    @(posedge clk);
    #1;
    if (wr) m_flags = ef;
    check("R12", "stored flags", int'(fq), int'(m_flags));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R12", "reset flags", int'(fq), 0);
    rst_n = 1'b1;
    // R1 carry out and zero, R5
    apply(16'hFFFF, 16'h0001, 0, 1, 1, "R1");
    // R1 add with stored carry
    apply(16'h1234, 16'h0001, 1, 1, 1, "R1");
    // R6 signed overflow on add, R4 nibble carry
    apply(16'h7FFF, 16'h0001, 0, 1, 1, "R6");
    apply(16'h000F, 16'h0001, 0, 1, 1, "R4");
    // R7 byte add with upper garbage
    apply(16'hAB7F, 16'hCD01, 0, 0, 1, "R7");
    apply(16'h12FF, 16'h3401, 0, 0, 1, "R7");
    // R2 borrow, then subtract with borrow reading it
    apply(16'h0000, 16'h0001, 2, 1, 1, "R2");
    apply(16'h0010, 16'h0001, 3, 1, 1, "R2");
    apply(16'h8000, 16'h0001, 2, 1, 1, "R6");
    apply(16'h0080, 16'h0001, 2, 0, 1, "R6");
    // R9 inc/dec with carry set
    apply(16'h0000, 16'h0001, 2, 1, 1, "R2");
    apply(16'hFFFF, 16'h0000, 7, 1, 1, "R9");
    apply(16'h0000, 16'h0000, 8, 1, 1, "R9");
    apply(16'h007F, 16'h0000, 7, 0, 1, "R6");
    // R8 logic clears carry and overflow, R3 parity
    apply(16'hF0F0, 16'h0FF3, 5, 1, 1, "R8");
    apply(16'h00FF, 16'h0F0F, 6, 1, 1, "R3");
    apply(16'hFF03, 16'h0000, 4, 1, 1, "R3");
    // R10 complement keeps flags
    apply(16'h0000, 16'h0001, 2, 1, 1, "R2");
    apply(16'h5A5A, 16'h0000, 9, 1, 1, "R10");
    apply(16'hFF5A, 16'h0000, 9, 0, 1, "R10");
    // R11 shifts
    apply(16'h8000, 16'h0000, 10, 1, 1, "R11");
    apply(16'h4000, 16'h0000, 10, 1, 1, "R11");
    apply(16'hFFC0, 16'h0000, 10, 0, 1, "R11");
    apply(16'h8001, 16'h0000, 11, 1, 1, "R11");
    apply(16'hFF81, 16'h0000, 11, 0, 1, "R11");
    // R12 hold without write, undefined opcodes
    apply(16'hFFFF, 16'h0001, 0, 1, 0, "R12");
    apply(16'hBEEF, 16'h1111, 13, 1, 1, "R12");
    apply(16'hBEEF, 16'h1111, 15, 0, 1, "R12");
    // back-to-back carry read with write
    for (int i = 0; i < 3000; i++) begin
      int o = $urandom_range(0, 15);
      apply(16'($urandom), 16'($urandom), o, 1'($urandom), 1'($urandom_range(0, 3) != 0), tag_of(o));
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL R12 watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule